// File: doc/BRIEF.md
# Opportunistic Per-Bank Refresh Scheduler

This block lives inside a DRAM memory controller and decides, cycle by cycle, whether a single bank of an eight-bank rank should receive a per-bank refresh, and which bank that should be. It watches whether each bank's request queue holds work, whether the controller is in a write-drain batch and which banks that batch targets, and a periodic refresh tick. When it commits to a refresh it raises a one-cycle command strobe with the bank index and holds that bank busy for the refresh latency, while the other banks stay free for accesses.

Each tick creates one refresh debt. A signed credit counter tracks how far the rank is ahead of or behind the nominal schedule. Banks with empty queues are refreshed early, while credit remains below the pull-in limit. A write drain pulls refreshes onto the banks absorbing writes. A bank with pending reads is left alone until the debt reaches the postponement limit, when a refresh is forced regardless of queue state. A per-bank round vector makes every bank receive one refresh before any bank receives a second.

The controller is built around a two-state machine. In ST_SCAN the block evaluates the candidates every cycle. The transition SCAN→ISSUE is taken when a force, drain or idle candidate exists, and the chosen bank is latched on that transition. ST_ISSUE drives the command for one cycle, and the transition ISSUE→SCAN is always taken on the next clock. If no candidate exists, the machine stays in ST_SCAN (SCAN→SCAN).

Top module: `bank_refresh_sched`

## Requirements
- R1: After reset, `ref_valid` is 0, `credit` is 0, `bank_busy` is all zero and no refresh is issued while every queue is non-empty and no drain is active.
- R2: Each cycle with `refresh_tick` high lowers `credit` by one, saturating at -CREDIT_MAX (default -8). Each cycle with `ref_valid` high raises it by one. When both happen in the same cycle, the value is unchanged.
- R3: A bank whose `queue_nonempty` bit is 1 is not refreshed while `credit` is above -CREDIT_MAX, unless a drain selects it (R6).
- R4: When `credit` equals -CREDIT_MAX, the next cycle issues a refresh to the lowest-index bank that is neither refreshed this round nor busy, whatever the queue and drain inputs.
- R5: While `credit` is below +CREDIT_MAX, the block refreshes eligible banks whose queue is empty, one at a time, choosing the lowest index first.
- R6: While `drain_mode` is 1 and `credit` is below +CREDIT_MAX, eligible banks whose `drain_target` bit is 1 are chosen ahead of idle banks, even when their queue is non-empty.
- R7: No refresh is issued while `credit` equals +CREDIT_MAX (default +8).
- R8: A bank refreshed in the current round is not chosen again until all banks have been refreshed. The round restarts when the last bank is refreshed.
- R9: After a refresh to bank b, `bank_busy[b]` is 1 for exactly REF_BUSY_CYC cycles, starting the cycle after the command. No refresh is issued to a busy bank.
- R10: `ref_valid` is a single-cycle pulse, raised in the cycle after the decision, with `ref_bank` holding the chosen bank index, in binary, for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_tick | input | 1 | One-cycle pulse each nominal refresh interval |
| queue_nonempty | input | NUM_BANKS | Bit b is 1 when bank b has queued requests |
| drain_mode | input | 1 | Controller is draining a write batch |
| drain_target | input | NUM_BANKS | Banks served by the current write batch |
| ref_valid | output | 1 | Per-bank refresh command strobe |
| ref_bank | output | $clog2(NUM_BANKS) | Bank index of the command |
| bank_busy | output | NUM_BANKS | Bank is under refresh and unavailable |
| credit | output | $clog2(CREDIT_MAX+1)+1 | Signed refresh credit (issued minus owed) |

## Verification
The bench keeps the default eight banks and a credit limit of eight, so the full postponement range, the forced refresh at -8 and the pull-in cap at +8 are all reached with a few dozen ticks. It shortens REF_BUSY_CYC to 3, so the busy window can be counted exactly. With that latency, a complete round followed by a second pull-in round runs inside a few dozen cycles while recently refreshed banks are still busy. This exposes the lowest-index order, the round restart and the pull-in cap within one short run.

// File: rtl/bank_refresh_pkg.sv
package bank_refresh_pkg;

    typedef enum logic {
        ST_SCAN  = 1'b0,
        ST_ISSUE = 1'b1
    } sched_state_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_FORCE = 2'd1,
        SRC_DRAIN = 2'd2,
        SRC_IDLE  = 2'd3
    } pick_src_e;

endpackage

// File: rtl/pick_lowest.sv
module pick_lowest #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/bank_busy_timer.sv
module bank_busy_timer #(
    parameter int CYC = 280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/refresh_credit.sv
module refresh_credit #(
    parameter int CMAX = 8,
    parameter int CW   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 grant,
    output logic signed [CW-1:0] cred
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cred <= '0;
        end else begin
            case ({tick, grant})
                2'b10: if (int'(cred) > -CMAX) cred <= cred - 1'b1;
                2'b01: cred <= cred + 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bank_refresh_sched.sv
module bank_refresh_sched
    import bank_refresh_pkg::*;
#(
    parameter  int NUM_BANKS    = 8,
    parameter  int CREDIT_MAX   = 8,
    parameter  int REF_BUSY_CYC = 280,
    localparam int BANK_W       = $clog2(NUM_BANKS),
    localparam int CRED_W       = $clog2(CREDIT_MAX + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     refresh_tick,
    input  logic [NUM_BANKS-1:0]     queue_nonempty,
    input  logic                     drain_mode,
    input  logic [NUM_BANKS-1:0]     drain_target,
    output logic                     ref_valid,
    output logic [BANK_W-1:0]        ref_bank,
    output logic [NUM_BANKS-1:0]     bank_busy,
    output logic signed [CRED_W-1:0] credit
);
    sched_state_e         state_q, state_d;
    pick_src_e            src_d;
    logic [BANK_W-1:0]    pick_d, pick_q;
    logic [NUM_BANKS-1:0] done_q, done_nx;
    logic [NUM_BANKS-1:0] avail, drain_set, idle_set;
    logic                 f_found, d_found, i_found;
    logic [BANK_W-1:0]    f_idx, d_idx, i_idx;
    logic                 at_floor, below_cap;

    // candidate sets: not yet refreshed this round and not under refresh
    always_comb begin
        avail     = ~done_q & ~bank_busy;
        drain_set = avail & drain_target & {NUM_BANKS{drain_mode}};
        idle_set  = avail & ~queue_nonempty;
        at_floor  = int'(credit) <= -CREDIT_MAX;
        below_cap = int'(credit) < CREDIT_MAX;
    end

    pick_lowest #(.N(NUM_BANKS), .IW(BANK_W)) u_pick_force (
        .cand(avail), .found(f_found), .idx(f_idx));
    pick_lowest #(.N(NUM_BANKS), .IW(BANK_W)) u_pick_drain (
        .cand(drain_set), .found(d_found), .idx(d_idx));
    pick_lowest #(.N(NUM_BANKS), .IW(BANK_W)) u_pick_idle (
        .cand(idle_set), .found(i_found), .idx(i_idx));

    // source priority: forced > write drain > idle bank
    always_comb begin
        src_d  = SRC_NONE;
        pick_d = '0;
        if (at_floor && f_found) begin
            src_d  = SRC_FORCE;
            pick_d = f_idx;
        end else if (below_cap && d_found) begin
            src_d  = SRC_DRAIN;
            pick_d = d_idx;
        end else if (below_cap && i_found) begin
            src_d  = SRC_IDLE;
            pick_d = i_idx;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN:  state_d = (src_d != SRC_NONE) ? ST_ISSUE : ST_SCAN;
            ST_ISSUE: state_d = ST_SCAN;
        endcase
    end

    always_comb begin
        done_nx = done_q | ({{(NUM_BANKS-1){1'b0}}, 1'b1} << pick_q);
    end

    // state register with the latched choice and round vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            pick_q  <= '0;
            done_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SCAN && src_d != SRC_NONE) begin
                pick_q <= pick_d;
            end
            if (state_q == ST_ISSUE) begin
                done_q <= (&done_nx) ? '0 : done_nx;
            end
        end
    end

    // outputs
    always_comb begin
        ref_valid = (state_q == ST_ISSUE);
        ref_bank  = pick_q;
    end

    refresh_credit #(.CMAX(CREDIT_MAX), .CW(CRED_W)) u_credit (
        .clk(clk), .rst_n(rst_n), .tick(refresh_tick),
        .grant(ref_valid), .cred(credit));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_busy
        bank_busy_timer #(.CYC(REF_BUSY_CYC)) u_tmr (
            .clk(clk), .rst_n(rst_n),
            .load(ref_valid && (pick_q == BANK_W'(b))),
            .busy(bank_busy[b]));
    end
endmodule

// File: rtl/bank_refresh_sched_chk.sv
module bank_refresh_sched_chk #(
    parameter int N    = 8,
    parameter int CMAX = 8,
    parameter int BW   = 3,
    parameter int CW   = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 refresh_tick,
    input logic [N-1:0]         queue_nonempty,
    input logic                 drain_mode,
    input logic [N-1:0]         drain_target,
    input logic                 ref_valid,
    input logic [BW-1:0]        ref_bank,
    input logic [N-1:0]         bank_busy,
    input logic signed [CW-1:0] credit
);
    logic [N-1:0]         q_d, tgt_d;
    logic                 drain_d, tick_d, val_d;
    logic [BW-1:0]        bank_d;
    logic signed [CW-1:0] cred_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_d <= '0; tgt_d <= '0; drain_d <= 1'b0; tick_d <= 1'b0;
            val_d <= 1'b0; bank_d <= '0; cred_d <= '0;
        end else begin
            q_d <= queue_nonempty; tgt_d <= drain_target; drain_d <= drain_mode;
            tick_d <= refresh_tick; val_d <= ref_valid; bank_d <= ref_bank;
            cred_d <= credit;
        end
    end

    p_credit_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(credit) >= -CMAX && int'(credit) <= CMAX);

    p_credit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(credit) == int'(cred_d) + (val_d ? 1 : 0)
                        - ((tick_d && int'(cred_d) > -CMAX) ? 1 : 0));

    p_postpone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> !(q_d[ref_bank] && !(drain_d && tgt_d[ref_bank])
                        && int'(cred_d) > -CMAX));

    p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(credit) <= -CMAX && !ref_valid) |=> ref_valid);

    p_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> int'(credit) < CMAX);

    p_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> !bank_busy[ref_bank]);

    p_busy_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        val_d |-> bank_busy[bank_d]);

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> !ref_valid);
endmodule

bind bank_refresh_sched bank_refresh_sched_chk #(
    .N(NUM_BANKS), .CMAX(CREDIT_MAX), .BW(BANK_W), .CW(CRED_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick),
    .queue_nonempty(queue_nonempty), .drain_mode(drain_mode),
    .drain_target(drain_target), .ref_valid(ref_valid), .ref_bank(ref_bank),
    .bank_busy(bank_busy), .credit(credit)
);

// File: tb/bank_refresh_sched_tb.sv
module bank_refresh_sched_tb;
    localparam int N    = 8;
    localparam int CMAX = 8;
    localparam int BUSY = 3;
    localparam int BW   = $clog2(N);
    localparam int CW   = $clog2(CMAX + 1) + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 refresh_tick = 1'b0;
    logic [N-1:0]         queue_nonempty = '1;
    logic                 drain_mode = 1'b0;
    logic [N-1:0]         drain_target = '0;
    logic                 ref_valid;
    logic [BW-1:0]        ref_bank;
    logic [N-1:0]         bank_busy;
    logic signed [CW-1:0] credit;

    int checks = 0;
    int fails  = 0;
    int nref   = 0;
    int busy0_cycles = 0;
    int log_bank [64];

    always #10 clk = ~clk;

    bank_refresh_sched #(.NUM_BANKS(N), .CREDIT_MAX(CMAX), .REF_BUSY_CYC(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick),
        .queue_nonempty(queue_nonempty), .drain_mode(drain_mode),
        .drain_target(drain_target), .ref_valid(ref_valid), .ref_bank(ref_bank),
        .bank_busy(bank_busy), .credit(credit));

    always @(negedge clk) begin
        if (rst_n && ref_valid && nref < 64) begin
            log_bank[nref] = int'(ref_bank);
            nref = nref + 1;
        end
        if (rst_n && bank_busy[0]) busy0_cycles = busy0_cycles + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_once();
        @(negedge clk) refresh_tick = 1'b1;
        @(negedge clk) refresh_tick = 1'b0;
        idle(2);
    endtask

    task automatic wait_refs(input int target);
        for (int k = 0; k < 80 && nref < target; k++) @(negedge clk);
        idle(3);
    endtask

    task automatic t_reset();
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(1);
        chk(ref_valid == 1'b0, "R1 ref_valid", int'(ref_valid), 0);
        chk(int'(credit) == 0, "R1 credit", int'(credit), 0);
        chk(bank_busy == '0, "R1 bank_busy", int'(bank_busy), 0);
        idle(6);
        chk(nref == 0, "R1 no refresh", nref, 0);
    endtask

    task automatic t_postpone();
        for (int i = 0; i < 7; i++) tick_once();
        chk(int'(credit) == -7, "R2 credit after 7 ticks", int'(credit), -7);
        chk(nref == 0, "R3 postponed while reads pending", nref, 0);
    endtask

    task automatic t_force();
        tick_once();
        wait_refs(1);
        chk(nref == 1, "R10 single forced command", nref, 1);
        chk(log_bank[0] == 0, "R4 forced bank", log_bank[0], 0);
        chk(int'(credit) == -7, "R2 credit after force", int'(credit), -7);
        idle(BUSY + 2);
        chk(busy0_cycles == BUSY, "R9 busy window", busy0_cycles, BUSY);
    endtask

    task automatic t_idle_pick();
        @(negedge clk) queue_nonempty = ~(N'(1) << 5);
        wait_refs(2);
        idle(6);
        chk(nref == 2, "R5 one idle refresh", nref, 2);
        chk(log_bank[1] == 5, "R5 idle bank chosen", log_bank[1], 5);
        @(negedge clk) queue_nonempty = ~((N'(1) << 3) | (N'(1) << 6));
        wait_refs(4);
        idle(6);
        chk(log_bank[2] == 3, "R5 lowest idle first", log_bank[2], 3);
        chk(log_bank[3] == 6, "R5 next idle", log_bank[3], 6);
        chk(nref == 4, "R8 no repeat within round", nref, 4);
        chk(int'(credit) == -4, "R2 credit after idle refreshes", int'(credit), -4);
    endtask

    task automatic t_drain();
        @(negedge clk) begin
            queue_nonempty = '1;
            drain_target   = (N'(1) << 0) | (N'(1) << 2) | (N'(1) << 7);
            drain_mode     = 1'b1;
        end
        wait_refs(6);
        idle(6);
        chk(log_bank[4] == 2, "R6 drain bank first", log_bank[4], 2);
        chk(log_bank[5] == 7, "R6 drain bank second", log_bank[5], 7);
        chk(nref == 6, "R8 done drain bank 0 skipped", nref, 6);
        chk(int'(credit) == -2, "R2 credit after drain", int'(credit), -2);
        @(negedge clk) begin
            drain_mode = 1'b0;
            drain_target = '0;
        end
    endtask

    task automatic t_round();
        int exp_seq [10] = '{1, 4, 0, 1, 2, 3, 4, 5, 6, 7};
        @(negedge clk) queue_nonempty = '0;
        wait_refs(16);
        idle(10);
        for (int i = 0; i < 10; i++)
            chk(log_bank[6 + i] == exp_seq[i], "R8 round order", log_bank[6 + i], exp_seq[i]);
        chk(nref == 16, "R7 pull-in stops at cap", nref, 16);
        chk(int'(credit) == CMAX, "R7 credit at cap", int'(credit), CMAX);
        tick_once();
        wait_refs(17);
        idle(6);
        chk(nref == 17, "R7 one pull-in after tick", nref, 17);
        chk(log_bank[16] == 0, "R8 new round restarts at bank 0", log_bank[16], 0);
        chk(int'(credit) == CMAX, "R2 credit back at cap", int'(credit), CMAX);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        t_reset();
        t_postpone();
        t_force();
        t_idle_pick();
        t_drain();
        t_round();
        finish_run();
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule